// File: doc/BRIEF.md
# Command Packet Queue for a Serial Display Link

This block sits between a register-mapped host and a downstream packet engine that serialises commands onto a display link. The host builds each outgoing command packet from two registers. The payload register feeds a word FIFO. The header register feeds a command FIFO. A long packet's payload words are written first, and its header is written after them. A short packet carries its two parameter bytes inside the header word and has no payload words.

The drain side hands the engine one header at a time. For a long packet it then hands over the exact number of payload words that the header's byte count calls for. Read responses from the link arrive on a response port and fill a read FIFO. The host drains that FIFO through the same payload register. A status register reports whether each FIFO is empty, whether the last read has completed, and whether any FIFO has overflowed.

Top module: `cmdpkt_host`

## Requirements
- R1: After reset the status word reads 0x0000002A: read FIFO empty at bit 1, write FIFO empty at bit 3, command FIFO empty at bit 5, read-done at bit 7 clear, and the overflow bits 8, 9 and 10 clear. Both engine valid outputs are low.
- R2: A header written at register address 0 reaches the engine with bits 23:0 unchanged: data type in 5:0, channel in 7:6, low byte or count-low in 15:8, high byte or count-high in 23:16. Bits 31:24 are dropped. A presented header holds steady until the engine accepts it.
- R3: A data type is long when its bit 3 is set and its bits 2:0 are not all zero. All other types are short. Accepting a short header moves no payload word, even when the write FIFO holds words.
- R4: Accepting a long header with byte count N = {bits 23:16, bits 15:8} is followed by exactly ceil(N/4) payload words. The last flag is raised on the final word. N = 0 gives no payload phase, and no header is offered while a payload phase is open.
- R5: Words written at register address 1 leave toward the engine in write order, and a word on offer holds steady until accepted.
- R6: Status bits 1, 3 and 5 follow the emptiness of the read, write and command FIFOs.
- R7: A read at address 1 returns the oldest response word, bytes lowest first, and removes it. A read while the read FIFO is empty returns 0 and changes nothing.
- R8: Read-done (bit 7) sets on a response-end pulse and clears when a header is accepted. When both happen in one cycle, the bit ends cleared.
- R9: A push into a full FIFO is dropped and sets a sticky overflow bit that stays set until reset: bit 8 for the command FIFO, bit 9 for the write FIFO, bit 10 for the read FIFO.
- R10: A response word arriving in the same cycle as a host read of the non-full read FIFO is kept, and the read returns the older word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 header, 1 payload, 2 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| eng_hdr_valid | output | 1 | Header on offer to the engine |
| eng_hdr_ready | input | 1 | Engine accepts the header |
| eng_hdr | output | 24 | Header word |
| eng_pld_valid | output | 1 | Payload word on offer |
| eng_pld_ready | input | 1 | Engine accepts the payload word |
| eng_pld_data | output | 32 | Payload word |
| eng_pld_last | output | 1 | Final payload word of the packet |
| rsp_valid | input | 1 | Response word strobe |
| rsp_data | input | 32 | Response word |
| rsp_end | input | 1 | End of a read response |

## Verification
Two events can land in the same cycle: a header push, which clears read-done, and a response-end pulse, which sets it. The bench drives both in one cycle and expects the status word to show the bit clear. The read FIFO can also be pushed by the response port and popped by the host in the same cycle. The bench checks that the host read returns the older word and that the new word survives for the next read. Overflow is provoked by stalling the engine or by leaving the read FIFO undrained. The bench then confirms that the dropped entry never appears downstream and that the overflow flag stays set.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;

   localparam int unsigned ADDR_W = 2;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned HDR_W  = 24;
   localparam int unsigned CNT_W  = 15;

   typedef enum logic [ADDR_W-1:0] {
      REG_HDR  = 2'd0,
      REG_PLD  = 2'd1,
      REG_STAT = 2'd2
   } reg_sel_e;

   localparam int unsigned ST_RX_EMPTY  = 1;
   localparam int unsigned ST_WR_EMPTY  = 3;
   localparam int unsigned ST_CMD_EMPTY = 5;
   localparam int unsigned ST_RD_DONE   = 7;
   localparam int unsigned ST_OVF_LSB   = 8;

   typedef struct packed {
      logic [7:0] cnt_hi;
      logic [7:0] cnt_lo;
      logic [1:0] chan;
      logic [5:0] dtype;
   } hdr_t;

   function automatic logic type_is_long(input logic [5:0] dt);
      return dt[3] & (dt[2:0] != 3'b000);
   endfunction

   function automatic logic [CNT_W-1:0] words_for(input logic [15:0] nbytes);
      logic [16:0] sum;
      sum = {1'b0, nbytes} + 17'd3;
      return sum[16:2];
   endfunction

endpackage

// File: rtl/cmdpkt_fifo.sv
module cmdpkt_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cmdpkt_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

endmodule

// File: rtl/cmdpkt_regs.sv
module cmdpkt_regs
   import cmdpkt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              cmd_full,
   input  logic              cmd_empty,
   input  logic              wr_full,
   input  logic              wr_empty,
   input  logic              rx_full,
   input  logic              rx_empty,
   input  logic [WORD_W-1:0] rx_head,
   input  logic              rsp_valid,
   input  logic              rsp_end,
   output logic              cmd_push,
   output logic              cmd_acc,
   output logic              wr_push,
   output logic              rx_pop,
   output logic              rd_done,
   output logic [2:0]        ovf
);

   logic [WORD_W-1:0] status;
   logic [WORD_W-1:0] rd_mux;
   logic [2:0]        ovf_hit;

   assign cmd_push = bus_wr_en & (bus_addr == REG_HDR);
   assign wr_push  = bus_wr_en & (bus_addr == REG_PLD);
   assign rx_pop   = bus_rd_en & (bus_addr == REG_PLD);
   assign cmd_acc  = cmd_push & ~cmd_full;

   assign ovf_hit = {rsp_valid & rx_full, wr_push & wr_full, cmd_push & cmd_full};

   always_comb begin
      status                 = '0;
      status[ST_RX_EMPTY]    = rx_empty;
      status[ST_WR_EMPTY]    = wr_empty;
      status[ST_CMD_EMPTY]   = cmd_empty;
      status[ST_RD_DONE]     = rd_done;
      status[ST_OVF_LSB+:3]  = ovf;
   end

   always_comb begin
      case (bus_addr)
         REG_PLD:  rd_mux = rx_empty ? '0 : rx_head;
         REG_STAT: rd_mux = status;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         rd_done   <= 1'b0;
         ovf       <= '0;
      end else begin
         if (bus_rd_en) bus_rdata <= rd_mux;
         if (cmd_acc)      rd_done <= 1'b0;
         else if (rsp_end) rd_done <= 1'b1;
         ovf <= ovf | ovf_hit;
      end
   end

endmodule

// File: rtl/cmdpkt_drain.sv
module cmdpkt_drain
   import cmdpkt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_empty,
   input  logic [HDR_W-1:0]  cmd_head,
   output logic              cmd_pop,
   input  logic              wr_empty,
   input  logic [WORD_W-1:0] wr_head,
   output logic              wr_pop,
   output logic              eng_hdr_valid,
   input  logic              eng_hdr_ready,
   output logic [HDR_W-1:0]  eng_hdr,
   output logic              eng_pld_valid,
   input  logic              eng_pld_ready,
   output logic [WORD_W-1:0] eng_pld_data,
   output logic              eng_pld_last
);

   typedef enum logic {PH_HDR, PH_PLD} phase_e;

   phase_e           phase;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] need;
   hdr_t             hdr;
   logic             hdr_hs, pld_hs;

   assign hdr  = hdr_t'(cmd_head);
   assign need = words_for({hdr.cnt_hi, hdr.cnt_lo});

   assign eng_hdr_valid = (phase == PH_HDR) & ~cmd_empty;
   assign eng_hdr       = cmd_head;
   assign hdr_hs        = eng_hdr_valid & eng_hdr_ready;
   assign cmd_pop       = hdr_hs;

   assign eng_pld_valid = (phase == PH_PLD) & ~wr_empty;
   assign eng_pld_data  = wr_head;
   assign eng_pld_last  = eng_pld_valid & (remain == CNT_W'(1));
   assign pld_hs        = eng_pld_valid & eng_pld_ready;
   assign wr_pop        = pld_hs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_HDR;
         remain <= '0;
      end else begin
         case (phase)
            PH_HDR: begin
               if (hdr_hs && type_is_long(hdr.dtype) && (need != '0)) begin
                  phase  <= PH_PLD;
                  remain <= need;
               end
            end
            PH_PLD: begin
               if (pld_hs) begin
                  remain <= remain - 1'b1;
                  if (remain == CNT_W'(1)) phase <= PH_HDR;
               end
            end
            default: phase <= PH_HDR;
         endcase
      end
   end

endmodule

// File: rtl/cmdpkt_host.sv
module cmdpkt_host
   import cmdpkt_pkg::*;
#(
   parameter int unsigned CMD_DEPTH = 4,
   parameter int unsigned WR_DEPTH  = 8,
   parameter int unsigned RD_DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_hdr_valid,
   input  logic              eng_hdr_ready,
   output logic [23:0]       eng_hdr,
   output logic              eng_pld_valid,
   input  logic              eng_pld_ready,
   output logic [31:0]       eng_pld_data,
   output logic              eng_pld_last,
   input  logic              rsp_valid,
   input  logic [31:0]       rsp_data,
   input  logic              rsp_end
);

   if (CMD_DEPTH < 2 || WR_DEPTH < 2 || RD_DEPTH < 2) begin : g_bad_cfg
      $error("cmdpkt_host: every FIFO depth must be at least 2");
   end

   logic              cmd_push, cmd_acc, cmd_pop, cmd_empty, cmd_full;
   logic [HDR_W-1:0]  cmd_head;
   logic              wr_push, wr_pop, wr_empty, wr_full;
   logic [WORD_W-1:0] wr_head;
   logic              rx_pop, rx_empty, rx_full;
   logic [WORD_W-1:0] rx_head;
   logic              rd_done;
   logic [2:0]        ovf;

   cmdpkt_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr_en (bus_wr_en),
      .bus_rd_en (bus_rd_en),
      .bus_addr  (bus_addr),
      .bus_rdata (bus_rdata),
      .cmd_full  (cmd_full),
      .cmd_empty (cmd_empty),
      .wr_full   (wr_full),
      .wr_empty  (wr_empty),
      .rx_full   (rx_full),
      .rx_empty  (rx_empty),
      .rx_head   (rx_head),
      .rsp_valid (rsp_valid),
      .rsp_end   (rsp_end),
      .cmd_push  (cmd_push),
      .cmd_acc   (cmd_acc),
      .wr_push   (wr_push),
      .rx_pop    (rx_pop),
      .rd_done   (rd_done),
      .ovf       (ovf)
   );

   cmdpkt_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (cmd_push),
      .push_data (bus_wdata[HDR_W-1:0]),
      .pop       (cmd_pop),
      .head      (cmd_head),
      .empty     (cmd_empty),
      .full      (cmd_full)
   );

   cmdpkt_fifo #(.WIDTH(WORD_W), .DEPTH(WR_DEPTH)) u_wr_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_push),
      .push_data (bus_wdata),
      .pop       (wr_pop),
      .head      (wr_head),
      .empty     (wr_empty),
      .full      (wr_full)
   );

   cmdpkt_fifo #(.WIDTH(WORD_W), .DEPTH(RD_DEPTH)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rsp_valid),
      .push_data (rsp_data),
      .pop       (rx_pop),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   cmdpkt_drain u_drain (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_empty     (cmd_empty),
      .cmd_head      (cmd_head),
      .cmd_pop       (cmd_pop),
      .wr_empty      (wr_empty),
      .wr_head       (wr_head),
      .wr_pop        (wr_pop),
      .eng_hdr_valid (eng_hdr_valid),
      .eng_hdr_ready (eng_hdr_ready),
      .eng_hdr       (eng_hdr),
      .eng_pld_valid (eng_pld_valid),
      .eng_pld_ready (eng_pld_ready),
      .eng_pld_data  (eng_pld_data),
      .eng_pld_last  (eng_pld_last)
   );

endmodule

// File: rtl/cmdpkt_host_chk.sv
module cmdpkt_host_chk
   import cmdpkt_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        eng_hdr_valid,
   input logic        eng_hdr_ready,
   input logic [23:0] eng_hdr,
   input logic        eng_pld_valid,
   input logic        eng_pld_ready,
   input logic [31:0] eng_pld_data,
   input logic        eng_pld_last,
   input logic        rsp_end,
   input logic        cmd_acc,
   input logic        rd_done,
   input logic [2:0]  ovf
);

   // R2: an offered header holds until taken
   p_hdr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_hdr_valid && !eng_hdr_ready |=> eng_hdr_valid && $stable(eng_hdr));

   // R3: a short header opens no payload phase
   p_short_no_pld_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_hdr_valid && eng_hdr_ready && !type_is_long(eng_hdr[5:0]) |=> !eng_pld_valid);

   // R4: header and payload offers never overlap; last only on a valid word
   p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_pld_valid |-> !eng_hdr_valid);
   p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_pld_last |-> eng_pld_valid);

   // R5: an offered payload word holds until taken
   p_pld_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_pld_valid && !eng_pld_ready |=> eng_pld_valid && $stable(eng_pld_data));

   // R8: accepted header clears completion, lone end pulse sets it
   p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_acc |=> !rd_done);
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_end && !cmd_acc |=> rd_done);

   // R9: overflow flags never fall
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

endmodule

bind cmdpkt_host cmdpkt_host_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .eng_hdr_valid (eng_hdr_valid),
   .eng_hdr_ready (eng_hdr_ready),
   .eng_hdr       (eng_hdr),
   .eng_pld_valid (eng_pld_valid),
   .eng_pld_ready (eng_pld_ready),
   .eng_pld_data  (eng_pld_data),
   .eng_pld_last  (eng_pld_last),
   .rsp_end       (rsp_end),
   .cmd_acc       (cmd_acc),
   .rd_done       (rd_done),
   .ovf           (ovf)
);

// File: tb/cmdpkt_host_tb.sv
module cmdpkt_host_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_hdr_valid, eng_hdr_ready = 1'b0;
   logic [23:0] eng_hdr;
   logic        eng_pld_valid, eng_pld_ready = 1'b0;
   logic [31:0] eng_pld_data;
   logic        eng_pld_last;
   logic        rsp_valid = 1'b0, rsp_end = 1'b0;
   logic [31:0] rsp_data = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   cmdpkt_host u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_hdr_valid(eng_hdr_valid), .eng_hdr_ready(eng_hdr_ready), .eng_hdr(eng_hdr),
      .eng_pld_valid(eng_pld_valid), .eng_pld_ready(eng_pld_ready),
      .eng_pld_data(eng_pld_data), .eng_pld_last(eng_pld_last),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_end(rsp_end)
   );

   localparam logic [1:0] A_HDR = 2'd0, A_PLD = 2'd1, A_STAT = 2'd2;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIFO FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic push_rsp(input logic [31:0] d);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic take_hdr(input string tag, input logic [23:0] exp);
      @(negedge clk);
      chk({tag, " hdr valid"}, {31'd0, eng_hdr_valid}, 32'd1);
      chk({tag, " hdr"}, {8'd0, eng_hdr}, {8'd0, exp});
      eng_hdr_ready = 1'b1;
      @(negedge clk);
      eng_hdr_ready = 1'b0;
   endtask

   task automatic take_pld(input string tag, input logic [31:0] exp, input logic last);
      chk({tag, " pld valid"}, {31'd0, eng_pld_valid}, 32'd1);
      chk({tag, " pld data"}, eng_pld_data, exp);
      chk({tag, " pld last"}, {31'd0, eng_pld_last}, {31'd0, last});
      eng_pld_ready = 1'b1;
      @(negedge clk);
      eng_pld_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] s;
      do_reset();
      chk("R1 valids", {30'd0, eng_hdr_valid, eng_pld_valid}, 32'd0);
      rd(A_STAT, s);
      chk("R1 status", s, 32'h2A);
   endtask

   task automatic t_short();
      logic [31:0] s;
      do_reset();
      wr(A_PLD, 32'hDEADBEEF);
      wr(A_HDR, 32'h77341215);
      take_hdr("R2 short", 24'h341215);
      chk("R3 no payload", {31'd0, eng_pld_valid}, 32'd0);
      chk("R3 idle", {31'd0, eng_hdr_valid}, 32'd0);
      rd(A_STAT, s);
      chk("R3 word kept R6", s, 32'h22);
   endtask

   task automatic t_long();
      logic [31:0] s;
      do_reset();
      wr(A_PLD, 32'h44332211);
      wr(A_PLD, 32'h00000055);
      wr(A_HDR, 32'hAB000569);
      take_hdr("R2 long", 24'h000569);
      take_pld("R5 w0", 32'h44332211, 1'b0);
      take_pld("R4 w1", 32'h00000055, 1'b1);
      chk("R4 done", {30'd0, eng_hdr_valid, eng_pld_valid}, 32'd0);
      rd(A_STAT, s);
      chk("R6 empty", s, 32'h2A);
   endtask

   task automatic t_counts();
      do_reset();
      wr(A_PLD, 32'h1);
      wr(A_PLD, 32'h2);
      wr(A_PLD, 32'h3);
      wr(A_HDR, 32'h00000039);
      wr(A_HDR, 32'h00000829);
      wr(A_HDR, 32'h00000129);
      take_hdr("R4 cnt0", 24'h000039);
      chk("R4 cnt0 no pld", {31'd0, eng_pld_valid}, 32'd0);
      take_hdr("R4 cnt8", 24'h000829);
      take_pld("R4 cnt8 w0", 32'h1, 1'b0);
      take_pld("R4 cnt8 w1", 32'h2, 1'b1);
      take_hdr("R4 cnt1", 24'h000129);
      take_pld("R4 cnt1 w0", 32'h3, 1'b1);
      chk("R4 cnt1 end", {31'd0, eng_hdr_valid}, 32'd0);
   endtask

   task automatic t_cmd_ovf();
      logic [31:0] s;
      do_reset();
      for (int i = 0; i < 5; i++) wr(A_HDR, 32'h00000005 | (i << 8));
      rd(A_STAT, s);
      chk("R9 cmd ovf", s, 32'h10A);
      for (int i = 0; i < 4; i++) take_hdr("R9 cmd order", 24'h000005 | 24'(i << 8));
      chk("R9 dropped", {31'd0, eng_hdr_valid}, 32'd0);
      rd(A_STAT, s);
      chk("R9 sticky", s, 32'h12A);
   endtask

   task automatic t_wr_ovf();
      logic [31:0] s;
      do_reset();
      for (int i = 1; i <= 9; i++) wr(A_PLD, 32'(i));
      rd(A_STAT, s);
      chk("R9 wr ovf", s, 32'h222);
      wr(A_HDR, 32'h00002029);
      take_hdr("R9 wr hdr", 24'h002029);
      for (int i = 1; i <= 8; i++) take_pld("R9 wr word", 32'(i), i == 8);
      chk("R9 ninth dropped", {31'd0, eng_pld_valid}, 32'd0);
      rd(A_STAT, s);
      chk("R9 wr sticky", s, 32'h22A);
   endtask

   task automatic t_rx();
      logic [31:0] s;
      do_reset();
      push_rsp(32'hA0A1A2A3);
      push_rsp(32'hB0B1B2B3);
      push_rsp(32'hC0C1C2C3);
      rd(A_STAT, s);
      chk("R6 rx not empty", s, 32'h28);
      rd(A_PLD, s); chk("R7 rx0", s, 32'hA0A1A2A3);
      rd(A_PLD, s); chk("R7 rx1", s, 32'hB0B1B2B3);
      rd(A_PLD, s); chk("R7 rx2", s, 32'hC0C1C2C3);
      rd(A_STAT, s);
      chk("R7 drained", s, 32'h2A);
      rd(A_PLD, s);
      chk("R7 empty read", s, 32'h0);
      rd(A_STAT, s);
      chk("R7 empty no effect", s, 32'h2A);
   endtask

   task automatic t_rx_ovf();
      logic [31:0] s;
      do_reset();
      for (int i = 0; i < 9; i++) push_rsp(32'h100 + 32'(i));
      rd(A_STAT, s);
      chk("R9 rx ovf", s, 32'h428);
      for (int i = 0; i < 8; i++) begin
         rd(A_PLD, s);
         chk("R9 rx order", s, 32'h100 + 32'(i));
      end
      rd(A_STAT, s);
      chk("R9 rx sticky", s, 32'h42A);
   endtask

   task automatic t_rx_same_cycle();
      logic [31:0] s;
      do_reset();
      push_rsp(32'h0000AAAA);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 32'h0000BBBB;
      bus_rd_en = 1'b1; bus_addr = A_PLD;
      @(negedge clk);
      rsp_valid = 1'b0; bus_rd_en = 1'b0;
      chk("R10 older word", bus_rdata, 32'h0000AAAA);
      rd(A_PLD, s);
      chk("R10 new word kept", s, 32'h0000BBBB);
      rd(A_STAT, s);
      chk("R10 empty after", s, 32'h2A);
   endtask

   task automatic t_done();
      logic [31:0] s;
      do_reset();
      @(negedge clk); rsp_end = 1'b1;
      @(negedge clk); rsp_end = 1'b0;
      rd(A_STAT, s);
      chk("R8 set", s, 32'hAA);
      wr(A_HDR, 32'h00000005);
      rd(A_STAT, s);
      chk("R8 clear", s, 32'h0A);
      take_hdr("R8 drain", 24'h000005);
      @(negedge clk); rsp_end = 1'b1;
      @(negedge clk); rsp_end = 1'b0;
      rd(A_STAT, s);
      chk("R8 set again", s, 32'hAA);
      @(negedge clk);
      rsp_end = 1'b1; bus_wr_en = 1'b1; bus_addr = A_HDR; bus_wdata = 32'h00000006;
      @(negedge clk);
      rsp_end = 1'b0; bus_wr_en = 1'b0;
      rd(A_STAT, s);
      chk("R8 collision clears", s, 32'h0A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_short();
      t_long();
      t_counts();
      t_cmd_ovf();
      t_wr_ovf();
      t_rx();
      t_rx_ovf();
      t_rx_same_cycle();
      t_done();
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule